// File: doc/BRIEF.md
# Interrupt-Capable General-Purpose I/O Bank

This block is a bank of 32 general-purpose pins with a flat word-addressed register port. Each pin can drive a value, be released as an input, or blink under hardware control. Every sensed input goes through a two-stage synchroniser and then a per-pin polarity inversion. The adjusted value is what software reads back. The same value feeds the interrupt logic.

The adjusted value can raise an interrupt in two ways. The first is a level path, where the adjusted value itself is the cause. The second is an edge path, where a rising transition of the adjusted value sets a sticky cause bit that software must clear. Each path has its own mask. The masked terms of each group of eight neighbouring pins are ORed into one summary line, so the bank presents four interrupt outputs to the system interrupt controller.

Software configures the bank through single-cycle register writes and combinational reads. Pad muxing and the system interrupt controller sit outside the block.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset the output, blink and polarity registers read 0, the direction register reads 0xFFFFFFFF (all pins inputs), the edge cause and both mask registers read 0, and no group interrupt is active.
- R2: Registers sit at byte addresses output 0x100, direction 0x104, blink 0x108, polarity 0x10C, data-in 0x110, edge cause 0x114, edge mask 0x118 and level mask 0x11C. Bit n of each register belongs to pin n. A write takes effect on the next clock edge. An address outside these eight words, or one that is not word aligned, reads 0.
- R3: A direction bit of 0 makes the pin an output: pins_oe is 1 and pins_out carries the output register bit. A direction bit of 1 releases the pin (pins_oe is 0).
- R4: Data-in reads the pin input XOR the polarity bit. A pin change becomes visible on the second clock edge after it is applied. Writes to data-in have no effect.
- R5: A pin whose level mask bit is 1 keeps its group line high for as long as its data-in bit is 1, and stops contributing when the bit returns to 0.
- R6: A 0-to-1 change of a data-in bit sets that pin's edge cause bit, and this includes a change caused by a polarity write. A 1-to-0 change sets nothing. A set cause bit stays set until software clears it.
- R7: A write to the edge cause register clears the bits written as 0 and keeps the bits written as 1. A rising edge in the same cycle as a clear leaves that bit set.
- R8: Group line g (g = 0..3) is the OR over pins 8g..8g+7 of (data-in AND level mask) and (edge cause AND edge mask). With both masks at 0 no group line is active.
- R9: A pin with its blink bit set shows a square wave on pins_out that changes every BLINK_HALF cycles. Clearing the blink bit restores the output register value.
- R10: A pin held high through reset records no edge cause once reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 12 | Byte address of the register access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr (combinational) |
| pins_in | input | 32 | Sensed pad levels |
| pins_out | output | 32 | Pad drive values |
| pins_oe | output | 32 | Pad drive enables, 1 = drive |
| group_irq | output | 4 | Summary interrupt, one per group of eight pins |

## Verification
The bench builds the bank with BLINK_HALF set to 5, in place of a divider of millions of cycles. This makes several full blink half-periods short enough to measure edge to edge inside one run. GROUP_SIZE stays at 8 and SYNC_STAGES at 2. With those values the two-edge input latency can be pinned down exactly. It also lets the bench line a cause clear up with a rising edge in the same cycle, and reach every one of the four group lines, including pin 31 at the top of the last group.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    localparam int GPIO_W = 32;
    localparam int ADDR_W = 12;

    localparam logic [ADDR_W-1:0] BANK_BASE = 12'h100;

    typedef logic [GPIO_W-1:0] pin_vec_t;

    // Word index within the bank; the order is the fixed address map.
    typedef enum logic [2:0] {
        RS_OUT   = 3'd0,
        RS_DIR   = 3'd1,
        RS_BLINK = 3'd2,
        RS_POL   = 3'd3,
        RS_DIN   = 3'd4,
        RS_CAUSE = 3'd5,
        RS_EMASK = 3'd6,
        RS_LMASK = 3'd7
    } reg_sel_e;

    typedef struct packed {
        logic     hit;
        reg_sel_e sel;
    } reg_dec_t;

    typedef struct packed {
        pin_vec_t out_val;
        pin_vec_t dir;
        pin_vec_t blink;
        pin_vec_t pol;
        pin_vec_t edge_mask;
        pin_vec_t level_mask;
    } bank_cfg_t;

    localparam pin_vec_t DIR_RESET = '1;

    function automatic reg_dec_t decode_addr(input logic [ADDR_W-1:0] a);
        reg_dec_t r;
        r.hit = (a[ADDR_W-1:5] == BANK_BASE[ADDR_W-1:5]) && (a[1:0] == 2'b00);
        r.sel = reg_sel_e'(a[4:2]);
        return r;
    endfunction

    // Clear-by-zero with new edges taking priority.
    function automatic pin_vec_t merge_cause(input pin_vec_t cur,
                                             input pin_vec_t keep,
                                             input pin_vec_t rise);
        return (cur & keep) | rise;
    endfunction

endpackage

// File: rtl/gpio_insync.sv
module gpio_insync
    import gpio_bank_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  pin_vec_t pins,
    input  pin_vec_t pol,
    output pin_vec_t din,
    output pin_vec_t rise
);

    localparam int LAST = STAGES - 1;

    pin_vec_t stg [STAGES];
    pin_vec_t prev_q;

    generate
        if (STAGES < 2) begin : g_bad_depth
            initial $error("gpio_insync needs at least two stages");
        end
    endgenerate

    // Synchroniser flops carry no reset so they fill while reset is held.
    always_ff @(posedge clk) begin
        stg[0] <= pins;
        for (int k = 1; k < STAGES; k++) begin
            stg[k] <= stg[k-1];
        end
    end

    assign din = stg[LAST] ^ pol;

    // Polarity resets to 0, so the post-reset data-in equals the last stage.
    always_ff @(posedge clk) begin
        if (rst) prev_q <= stg[LAST];
        else     prev_q <= din;
    end

    assign rise = din & ~prev_q;

endmodule

// File: rtl/gpio_blink_gen.sv
module gpio_blink_gen #(
    parameter int HALF = 12_500_000
) (
    input  logic clk,
    input  logic rst,
    output logic phase
);

    localparam int CNT_W = (HALF > 2) ? $clog2(HALF) : 1;
    localparam logic [CNT_W-1:0] WRAP = CNT_W'(HALF - 1);

    logic [CNT_W-1:0] cnt_q;

    generate
        if (HALF < 2) begin : g_bad_half
            initial $error("gpio_blink_gen needs HALF >= 2");
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            phase <= 1'b0;
        end else if (cnt_q == WRAP) begin
            cnt_q <= '0;
            phase <= ~phase;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
    import gpio_bank_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  pin_vec_t          wdata,
    input  pin_vec_t          din,
    input  pin_vec_t          rise,
    output bank_cfg_t         cfg_q,
    output pin_vec_t          cause_q,
    output pin_vec_t          rdata
);

    reg_dec_t dec;
    logic     wr_hit;
    pin_vec_t keep;

    assign dec    = decode_addr(addr);
    assign wr_hit = wr_en && dec.hit;
    assign keep   = (wr_hit && dec.sel == RS_CAUSE) ? wdata : '1;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '{out_val: '0, dir: DIR_RESET, blink: '0, pol: '0,
                       edge_mask: '0, level_mask: '0};
        end else if (wr_hit) begin
            case (dec.sel)
                RS_OUT:   cfg_q.out_val    <= wdata;
                RS_DIR:   cfg_q.dir        <= wdata;
                RS_BLINK: cfg_q.blink      <= wdata;
                RS_POL:   cfg_q.pol        <= wdata;
                RS_EMASK: cfg_q.edge_mask  <= wdata;
                RS_LMASK: cfg_q.level_mask <= wdata;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cause_q <= '0;
        else     cause_q <= merge_cause(cause_q, keep, rise);
    end

    always_comb begin
        rdata = '0;
        if (dec.hit) begin
            case (dec.sel)
                RS_OUT:   rdata = cfg_q.out_val;
                RS_DIR:   rdata = cfg_q.dir;
                RS_BLINK: rdata = cfg_q.blink;
                RS_POL:   rdata = cfg_q.pol;
                RS_DIN:   rdata = din;
                RS_CAUSE: rdata = cause_q;
                RS_EMASK: rdata = cfg_q.edge_mask;
                RS_LMASK: rdata = cfg_q.level_mask;
                default:  rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/gpio_irq_reduce.sv
module gpio_irq_reduce
    import gpio_bank_pkg::*;
#(
    parameter int GROUP_SIZE = 8,
    localparam int NUM_GROUPS = GPIO_W / GROUP_SIZE
) (
    input  pin_vec_t              level_term,
    input  pin_vec_t              edge_term,
    output logic [NUM_GROUPS-1:0] group_irq
);

    generate
        if (GPIO_W % GROUP_SIZE != 0) begin : g_bad_group
            initial $error("group size must divide the pin count");
        end
        for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
            assign group_irq[g] = |(level_term[g*GROUP_SIZE +: GROUP_SIZE] |
                                    edge_term[g*GROUP_SIZE +: GROUP_SIZE]);
        end
    endgenerate

endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
    import gpio_bank_pkg::*;
#(
    parameter int GROUP_SIZE  = 8,
    parameter int SYNC_STAGES = 2,
    parameter int BLINK_HALF  = 12_500_000,
    localparam int NUM_GROUPS = GPIO_W / GROUP_SIZE
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [GPIO_W-1:0]     wdata,
    output logic [GPIO_W-1:0]     rdata,
    input  logic [GPIO_W-1:0]     pins_in,
    output logic [GPIO_W-1:0]     pins_out,
    output logic [GPIO_W-1:0]     pins_oe,
    output logic [NUM_GROUPS-1:0] group_irq
);

    bank_cfg_t cfg_q;
    pin_vec_t  cause_q;
    pin_vec_t  din;
    pin_vec_t  rise_vec;
    logic      blink_phase;

    gpio_insync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .pins (pins_in),
        .pol  (cfg_q.pol),
        .din  (din),
        .rise (rise_vec)
    );

    gpio_regfile u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .addr    (addr),
        .wdata   (wdata),
        .din     (din),
        .rise    (rise_vec),
        .cfg_q   (cfg_q),
        .cause_q (cause_q),
        .rdata   (rdata)
    );

    gpio_blink_gen #(.HALF(BLINK_HALF)) u_blink (
        .clk   (clk),
        .rst   (rst),
        .phase (blink_phase)
    );

    gpio_irq_reduce #(.GROUP_SIZE(GROUP_SIZE)) u_reduce (
        .level_term (din & cfg_q.level_mask),
        .edge_term  (cause_q & cfg_q.edge_mask),
        .group_irq  (group_irq)
    );

    assign pins_out = (cfg_q.blink & {GPIO_W{blink_phase}}) |
                      (~cfg_q.blink & cfg_q.out_val);
    assign pins_oe  = ~cfg_q.dir;

endmodule

// File: rtl/gpio_irq_bank_checker.sv
module gpio_irq_bank_checker
    import gpio_bank_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input pin_vec_t          wdata,
    input pin_vec_t          pins_oe,
    input logic              irq_any,
    input pin_vec_t          cause,
    input pin_vec_t          rise,
    input pin_vec_t          edge_mask,
    input pin_vec_t          level_mask
);

    localparam logic [ADDR_W-1:0] A_DIR   = BANK_BASE + 12'h004;
    localparam logic [ADDR_W-1:0] A_CAUSE = BANK_BASE + 12'h014;

    // R1: first cycle out of reset is quiet
    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!irq_any && cause == '0));

    // R3: a direction write shows up inverted on the enables
    p_dir_write_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == A_DIR) |=> (pins_oe == ~$past(wdata)));

    // R6: cause bits only fall through a write to the cause word
    p_cause_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && addr == A_CAUSE) |=> ((cause & $past(cause)) == $past(cause)));

    // R7: a detected rise is always recorded, even against a clear
    p_edge_wins_r7: assert property (@(posedge clk) disable iff (rst)
        (rise != '0) |=> ((cause & $past(rise)) == $past(rise)));

    // R8: nothing unmasked means no summary line
    p_masked_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        (edge_mask == '0 && level_mask == '0) |-> !irq_any);

endmodule

bind gpio_irq_bank gpio_irq_bank_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .addr       (addr),
    .wdata      (wdata),
    .pins_oe    (pins_oe),
    .irq_any    (|group_irq),
    .cause      (cause_q),
    .rise       (rise_vec),
    .edge_mask  (cfg_q.edge_mask),
    .level_mask (cfg_q.level_mask)
);

// File: tb/gpio_irq_bank_test.sv
module gpio_irq_bank_test;

    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 5;

    localparam logic [11:0] A_OUT   = 12'h100;
    localparam logic [11:0] A_DIR   = 12'h104;
    localparam logic [11:0] A_BLINK = 12'h108;
    localparam logic [11:0] A_POL   = 12'h10C;
    localparam logic [11:0] A_DIN   = 12'h110;
    localparam logic [11:0] A_CAUSE = 12'h114;
    localparam logic [11:0] A_EMASK = 12'h118;
    localparam logic [11:0] A_LMASK = 12'h11C;

    localparam int K_RD  = 0;
    localparam int K_OUT = 1;
    localparam int K_OE  = 2;
    localparam int K_IRQ = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [31:0] pins_in = 32'h0000_00FF;
    logic [31:0] pins_out;
    logic [31:0] pins_oe;
    logic [3:0]  group_irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        int          kind;
        logic [31:0] exp;
        logic [31:0] mask;
        string       req;
        string       what;
    } sb_item_t;

    sb_item_t sb[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_irq_bank #(.GROUP_SIZE(8), .SYNC_STAGES(2), .BLINK_HALF(HALF)) uut (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .addr      (addr),
        .wdata     (wdata),
        .rdata     (rdata),
        .pins_in   (pins_in),
        .pins_out  (pins_out),
        .pins_oe   (pins_oe),
        .group_irq (group_irq)
    );

    function automatic void record(bit ok, string req, string what,
                                   logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
        end
    endfunction

    // Monitor: pops expected items and compares against the outputs.
    always @(negedge clk) begin
        while (sb.size() > 0) begin
            sb_item_t it;
            logic [31:0] obs;
            it = sb.pop_front();
            case (it.kind)
                K_RD:    obs = rdata;
                K_OUT:   obs = pins_out;
                K_OE:    obs = pins_oe;
                default: obs = {28'd0, group_irq};
            endcase
            record((obs & it.mask) == (it.exp & it.mask), it.req, it.what,
                   obs & it.mask, it.exp & it.mask);
        end
    end

    task automatic expect_val(int kind, logic [11:0] a, logic [31:0] e,
                              logic [31:0] m, string req, string what);
        sb_item_t it;
        addr = a;
        #1;
        it.kind = kind; it.exp = e; it.mask = m; it.req = req; it.what = what;
        sb.push_back(it);
        @(negedge clk);
        #1;
    endtask

    task automatic exp_reg(logic [11:0] a, logic [31:0] e, string req, string what);
        expect_val(K_RD, a, e, '1, req, what);
    endtask

    task automatic exp_irq(logic [3:0] e, string req, string what);
        expect_val(K_IRQ, addr, {28'd0, e}, '1, req, what);
    endtask

    task automatic write_reg(logic [11:0] a, logic [31:0] d);
        @(posedge clk); #1;
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic set_pins(logic [31:0] v);
        @(posedge clk); #1;
        pins_in = v;
    endtask

    task automatic step(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        repeat (5) @(posedge clk);
        #1;
        // R1: reset state (sampled while reset still holds the registers)
        exp_reg(A_OUT,   32'h0,         "R1", "output reset");
        exp_reg(A_DIR,   32'hFFFF_FFFF, "R1", "direction reset");
        exp_reg(A_BLINK, 32'h0,         "R1", "blink reset");
        exp_reg(A_POL,   32'h0,         "R1", "polarity reset");
        exp_reg(A_CAUSE, 32'h0,         "R1", "cause reset");
        exp_reg(A_EMASK, 32'h0,         "R1", "edge mask reset");
        exp_reg(A_LMASK, 32'h0,         "R1", "level mask reset");
        exp_irq(4'h0, "R1", "irq reset");
        expect_val(K_OE, addr, 32'h0, '1, "R1", "oe reset");
        @(posedge clk); #1;
        rst = 1'b0;

        // R10: pins high through reset leave no cause behind
        step(4);
        exp_reg(A_CAUSE, 32'h0, "R10", "no edge after reset");
        exp_reg(A_DIN, 32'h0000_00FF, "R4", "data-in of held pins");

        // R2: readback and unmapped words
        write_reg(A_OUT, 32'h1234_5678);
        exp_reg(A_OUT, 32'h1234_5678, "R2", "output readback");
        write_reg(A_BLINK, 32'hC3C3_0000);
        exp_reg(A_BLINK, 32'hC3C3_0000, "R2", "blink readback");
        write_reg(A_BLINK, 32'h0);
        write_reg(A_EMASK, 32'hDEAD_BEEF);
        exp_reg(A_EMASK, 32'hDEAD_BEEF, "R2", "edge mask readback");
        write_reg(A_EMASK, 32'h0);
        write_reg(A_LMASK, 32'h0F0F_F0F0);
        exp_reg(A_LMASK, 32'h0F0F_F0F0, "R2", "level mask readback");
        write_reg(A_LMASK, 32'h0);
        exp_reg(12'h120, 32'h0, "R2", "unmapped word");
        exp_reg(12'h105, 32'h0, "R2", "misaligned address");

        // R3: direction and drive
        write_reg(A_DIR, 32'h0F0F_00F0);
        exp_reg(A_DIR, 32'h0F0F_00F0, "R2", "direction readback");
        expect_val(K_OE, addr, 32'hF0F0_FF0F, '1, "R3", "enables from direction");
        expect_val(K_OUT, addr, 32'h1234_5678, 32'hF0F0_FF0F, "R3", "driven pins");
        write_reg(A_DIR, 32'hFFFF_FFFF);
        expect_val(K_OE, addr, 32'h0, '1, "R3", "all released");
        write_reg(A_OUT, 32'h0);

        // R4: polarity inversion, read-only data-in
        write_reg(A_POL, 32'h0000_0F0F);
        exp_reg(A_POL, 32'h0000_0F0F, "R2", "polarity readback");
        exp_reg(A_DIN, 32'h0000_0FF0, "R4", "inverted data-in");
        write_reg(A_DIN, 32'h1234_5678);
        exp_reg(A_DIN, 32'h0000_0FF0, "R4", "data-in write ignored");
        write_reg(A_POL, 32'h0);
        write_reg(A_CAUSE, 32'h0);
        exp_reg(A_CAUSE, 32'h0, "R7", "cause cleared");

        // R4 timing and R6 rising edge
        set_pins(32'h0001_0000);
        step(1);
        exp_reg(A_DIN, 32'h0000_00FF, "R4", "one edge after change");
        step(1);
        exp_reg(A_DIN, 32'h0001_0000, "R4", "two edges after change");
        step(1);
        exp_reg(A_CAUSE, 32'h0001_0000, "R6", "rise recorded, falls ignored");
        write_reg(A_CAUSE, 32'h0);
        set_pins(32'h0);
        step(3);
        exp_reg(A_CAUSE, 32'h0, "R6", "falling edge sets nothing");

        // R6: polarity write produces a rise
        write_reg(A_POL, 32'h0010_0000);
        step(1);
        exp_reg(A_CAUSE, 32'h0010_0000, "R6", "polarity-induced rise");
        write_reg(A_POL, 32'h0);
        write_reg(A_CAUSE, 32'h0);

        // R7: clear by zero, keep by one, edge beats clear
        set_pins(32'h0003_0000);
        step(3);
        exp_reg(A_CAUSE, 32'h0003_0000, "R6", "two rises");
        write_reg(A_CAUSE, 32'h0002_0000);
        exp_reg(A_CAUSE, 32'h0002_0000, "R7", "bit written 1 kept");
        set_pins(32'h0007_0000);
        step(1);
        write_reg(A_CAUSE, 32'h0);
        exp_reg(A_CAUSE, 32'h0004_0000, "R7", "edge wins over clear");
        write_reg(A_CAUSE, 32'h0);

        // R5 / R8: level path and grouping
        write_reg(A_LMASK, 32'h0001_0000);
        exp_irq(4'b0100, "R5", "level pin 16 to group 2");
        write_reg(A_LMASK, 32'h0000_0100);
        exp_irq(4'b0000, "R5", "masked-in pin low");
        set_pins(32'h0007_0100);
        step(2);
        exp_irq(4'b0010, "R8", "pin 8 to group 1");
        set_pins(32'h0007_0000);
        step(2);
        exp_irq(4'b0000, "R5", "level released");
        write_reg(A_LMASK, 32'h8000_0000);
        set_pins(32'h8000_0000);
        step(2);
        exp_irq(4'b1000, "R8", "pin 31 to group 3");
        write_reg(A_LMASK, 32'h0);
        write_reg(A_CAUSE, 32'h0);

        // R8 / R6: edge path
        set_pins(32'h8000_0001);
        step(3);
        exp_reg(A_CAUSE, 32'h0000_0001, "R6", "pin 0 rise");
        exp_irq(4'b0000, "R8", "edge masked off");
        write_reg(A_EMASK, 32'h0000_0001);
        exp_irq(4'b0001, "R8", "edge pin 0 to group 0");
        set_pins(32'h8000_0000);
        step(2);
        exp_irq(4'b0001, "R6", "edge cause sticky");
        write_reg(A_CAUSE, 32'h0);
        exp_irq(4'b0000, "R7", "edge irq cleared");
        write_reg(A_EMASK, 32'h0);

        // R9: blink period
        write_reg(A_DIR, 32'hFFFF_FFDF);
        write_reg(A_BLINK, 32'h0000_0020);
        begin
            int last_chg = -1;
            int intervals = 0;
            logic prev_v;
            @(negedge clk);
            prev_v = pins_out[5];
            for (int i = 1; i <= 8 * HALF; i++) begin
                @(negedge clk);
                if (pins_out[5] !== prev_v) begin
                    if (last_chg >= 0) begin
                        intervals++;
                        record((i - last_chg) == HALF, "R9", "blink interval",
                               32'(i - last_chg), 32'(HALF));
                    end
                    last_chg = i;
                    prev_v = pins_out[5];
                end
            end
            record(intervals >= 2, "R9", "blink intervals seen",
                   32'(intervals), 32'd2);
        end
        write_reg(A_OUT, 32'h0000_0020);
        write_reg(A_BLINK, 32'h0);
        expect_val(K_OUT, addr, 32'h0000_0020, 32'h0000_0020, "R9", "static value restored");
        write_reg(A_OUT, 32'h0);
        expect_val(K_OUT, addr, 32'h0, 32'h0000_0020, "R9", "static low");

        done = 1;
        finish_run();
    end

endmodule